// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block sits between a synchronous host request port and an external asynchronous static RAM of 32K bytes. The host hands over one request at a time: a read or a write, a 15-bit word address and, for writes, an 8-bit data byte. The controller turns each request into a sequence on the memory's active-low select, write-strobe and output-gate pins. It also drives the address and controls the controller's own half of the shared data bus. Read results come back on a response port as a byte with a one-cycle valid pulse.

The memory's timing minimums are given in picoseconds, together with the clock period, as parameters. The controller turns each one into a wait-state count: the time divided by the clock period, rounded up, and never less than one cycle. Writes are strobe-controlled, so the memory captures the byte when the write strobe rises. The controller keeps driving the byte for one more clock after that edge. The controller drives the data bus only while the memory's output gate is closed, so the two sides never drive the bus at the same time.

Back-pressure rules: a request transfers on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low from the cycle after acceptance until the memory cycle finishes. While `req_ready` is low, the host must keep `req_valid` and the request fields steady. The response port has no back-pressure: the host must take `rsp_rdata` on the single cycle that `rsp_valid` is high.

Top module: `sram_port_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: In every cycle where `req_ready` is 1, no request is in progress: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1 (standby).
- R3: A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the cycle after acceptance and stays 0 until that memory cycle has finished. Only one request is ever outstanding.
- R4: A read (`req_wr`=0) holds `mem_ce_n`=0, `mem_we_n`=1 and `mem_oe_n`=0 for the read wait count. It then returns the byte stored at the address on `rsp_rdata`, with `rsp_valid`=1 for exactly one cycle.
- R5: A write (`req_wr`=1) holds `mem_we_n`=0 with `mem_ce_n`=0 and `mem_oe_n`=1. When `mem_we_n` rises, `mem_ce_n` is still 0 and `mem_dq_oe`=1 with the write byte on `mem_dq_o`. That byte stays driven for one clock after the rise.
- R6: `mem_dq_oe` is never 1 in a cycle where `mem_oe_n` is 0. The controller and the memory never drive the data bus in the same cycle.
- R7: `mem_addr` does not change in any two consecutive cycles where `mem_ce_n` is 0.
- R8: The read wait count is max(1, ceil(t/period)) over the address-access, read-cycle and output-gate times. The write wait count is max(1, ceil(t/period)) of the write-cycle time. With the defaults (8 ns period, 12/12/12/6 ns), both counts are 2 cycles.
- R9: Between the cycle where `mem_oe_n` returns to 1 after a read and the first later cycle with `mem_dq_oe`=1, there is at least one cycle with both `mem_oe_n`=1 and `mem_dq_oe`=0.
- R10: A read returns the byte written by the latest earlier write to the same address, including at addresses 0x0000 and 0x7FFF. A location never written reads as 0x00 in the bench memory model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: read byte valid |
| rsp_rdata | output | 8 | Read byte |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the controller's bus driver |
| mem_dq_i | input | 8 | Byte seen on the bus from the memory |

## Verification
The host port receives isolated writes and reads at the lowest and highest addresses and in the middle of the array. It also receives back-to-back reads, reads of never-written locations, and alternating write/read pairs where each read follows a write to the same address at once. A read placed directly before a write checks that the bus turnaround gap still appears when requests arrive as fast as the handshake allows. The memory model measures strobe and gate widths against the computed wait counts, and it counts any cycle in which both sides drive the bus. Read-back mismatches therefore separate lost writes from wrong timing and from bus contention.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic [2:0] {
    SP_IDLE,
    SP_SETUP,
    SP_WPULSE,
    SP_WHOLD,
    SP_RACT
  } sp_state_e;

  function automatic int unsigned sp_wait(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned sp_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("timer step"); // R8
endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          in_wr,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  output logic          hold_wr,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_wr   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else if (take) begin
      hold_wr   <= in_wr;
      hold_addr <= in_addr;
      hold_data <= in_data;
    end
  end
endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_port_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int CLK_PS  = 8000,
  parameter int T_AA_PS = 12000,
  parameter int T_RC_PS = 12000,
  parameter int T_WC_PS = 12000,
  parameter int T_OE_PS = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned N_RD = sp_max(sp_max(sp_wait(T_AA_PS, CLK_PS), sp_wait(T_RC_PS, CLK_PS)),
                                        sp_wait(T_OE_PS, CLK_PS));
  localparam int unsigned N_WR = sp_wait(T_WC_PS, CLK_PS);
  localparam int CW = $clog2(sp_max(N_RD, N_WR) + 1);

  sp_state_e state_q, state_d;
  logic          accept;
  logic          hold_wr;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;

  assign req_ready = (state_q == SP_IDLE);
  assign accept    = req_valid && req_ready;

  sram_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(accept),
    .in_wr(req_wr), .in_addr(req_addr), .in_data(req_wdata),
    .hold_wr(hold_wr), .hold_addr(mem_addr), .hold_data(mem_dq_o)
  );

  assign tmr_load = (state_q == SP_SETUP);
  assign tmr_val  = hold_wr ? CW'(N_WR - 1) : CW'(N_RD - 1);

  sram_wait_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SP_IDLE:   if (accept) state_d = SP_SETUP;
      SP_SETUP:  state_d = hold_wr ? SP_WPULSE : SP_RACT;
      SP_WPULSE: if (tmr_done) state_d = SP_WHOLD;
      SP_WHOLD:  state_d = SP_IDLE;
      SP_RACT:   if (tmr_done) state_d = SP_IDLE;
      default:   state_d = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SP_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= (state_q == SP_RACT) && tmr_done;
      if ((state_q == SP_RACT) && tmr_done) rsp_rdata <= mem_dq_i;
    end
  end

  assign mem_ce_n  = (state_q == SP_IDLE);
  assign mem_we_n  = (state_q != SP_WPULSE);
  assign mem_oe_n  = (state_q != SP_RACT);
  assign mem_dq_oe = (state_q == SP_WPULSE) || (state_q == SP_WHOLD);

  AST_STANDBY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n)) else $error("standby"); // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready) else $error("ready"); // R3
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid) else $error("rsp pulse"); // R4
  AST_WE_RISE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_o))) else $error("we rise"); // R5
  AST_WRITE_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n)) else $error("write pins"); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n) else $error("contention"); // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)) else $error("addr"); // R7
  AST_TURNAROUND_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !mem_dq_oe) else $error("turnaround"); // R9
endmodule

// File: tb/sram_port_ctrl_tb.sv
`timescale 1ns/1ps
module sram_port_ctrl_tb_top;
  localparam int EXP_RD = 2;
  localparam int EXP_WR = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_wr = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  model_q = 8'h00;

  int total = 0, bad = 0;
  logic [7:0] model_mem [int];
  logic [7:0] shadow [int];
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  sram_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(model_q)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // memory model and protocol monitor
  int  we_low = 0, oe_low = 0, gap = 0;
  int  viol_r2 = 0, viol_r6 = 0, viol_r7 = 0, viol_r5 = 0;
  bit  prev_we = 1'b1, prev_oe = 1'b1, prev_ce = 1'b1, prev_dqoe = 1'b0, after_read = 1'b0;
  logic [14:0] prev_addr = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit mdrive = !mem_ce_n && !mem_oe_n && mem_we_n;
      if (req_ready && !(mem_ce_n && mem_we_n && mem_oe_n)) viol_r2++;
      if (mem_dq_oe && (mdrive || !mem_oe_n)) viol_r6++;
      if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) viol_r7++;
      if (!mem_we_n && (!mem_oe_n || mem_ce_n)) viol_r5++;
      if (!mem_we_n) we_low++;
      if (!mem_oe_n) oe_low++;
      if (!prev_we && mem_we_n) begin
        chk(!mem_ce_n && mem_dq_oe, "R5", "we rise with data driven", mem_dq_oe, 1);
        chk(we_low == EXP_WR, "R8", "write strobe width", we_low, EXP_WR);
        model_mem[int'(mem_addr)] = mem_dq_o;
        we_low = 0;
      end
      if (!prev_we && mem_we_n && 0) ;
      if (prev_dqoe && !mem_we_n && 0) ;
      if (!prev_oe && mem_oe_n) begin
        chk(oe_low == EXP_RD, "R8", "read gate width", oe_low, EXP_RD);
        oe_low = 0;
      end
      if (!mem_oe_n) begin gap = 0; after_read = 1'b1; end
      else if (!mem_dq_oe) gap++;
      if (mem_dq_oe && !prev_dqoe && after_read) begin
        chk(gap >= 1, "R9", "turnaround idle cycles", gap, 1);
        after_read = 1'b0;
      end
      if (mem_dq_oe && !prev_dqoe && !mem_we_n == 1'b0)
        chk(1'b0, "R5", "driver on without strobe", 0, 1);
      model_q = mdrive ? (model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00) : 8'h00;
      if (rsp_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", "unexpected response", rsp_rdata, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(rsp_rdata === e, "R10", "read data", rsp_rdata, e);
        end
      end
    end
    prev_we = mem_we_n; prev_oe = mem_oe_n; prev_ce = mem_ce_n;
    prev_dqoe = mem_dq_oe; prev_addr = mem_addr;
  end

  task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R3", "ready low after accept", req_ready, 0);
    if (wr) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
        "R1", "reset outputs", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid}, 6'b111010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && req_ready && !rsp_valid, "R1", "after reset", {mem_ce_n, req_ready, rsp_valid}, 3'b110);
    issue(1'b1, 15'h0000, 8'hA5);
    issue(1'b1, 15'h7FFF, 8'h3C);
    issue(1'b1, 15'h1234, 8'h0F);
    issue(1'b0, 15'h7FFF, 8'h00);
    issue(1'b0, 15'h0000, 8'h00);
    issue(1'b0, 15'h1234, 8'h00);
    issue(1'b0, 15'h0100, 8'h00);
    for (int i = 0; i < 8; i++) begin
      issue(1'b1, 15'(i * 37 + 5), 8'(i * 29 + 1));
      issue(1'b0, 15'(i * 37 + 5), 8'h00);
    end
    issue(1'b0, 15'h7FFF, 8'h00);
    issue(1'b1, 15'h7FFF, 8'hC3);
    issue(1'b0, 15'h7FFF, 8'h00);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all reads answered", exp_q.size(), 0);
    chk(viol_r2 == 0, "R2", "standby while ready", viol_r2, 0);
    chk(viol_r5 == 0, "R5", "write pins", viol_r5, 0);
    chk(viol_r6 == 0, "R6", "bus contention cycles", viol_r6, 0);
    chk(viol_r7 == 0, "R7", "address changes while selected", viol_r7, 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule